// File: doc/BRIEF.md
# Subtractive GCD Coprocessor

This block computes the greatest common divisor of two unsigned words by repeated subtraction. It runs without end. It pulls a first operand from one input FIFO and then a second operand from another input FIFO. It reduces the pair in place until the two values match, pushes the result into an output FIFO, and then goes back for the next pair. Only one pair is in flight at a time.

Each channel follows a FIFO-style handshake, which acts as a valid/ready stream. An input channel offers data together with an availability flag. The block answers with a take strobe in the same cycle, and the word is consumed at that clock edge. The output channel offers a space flag. The block raises its put strobe with the result in a cycle where space is present. Back-pressure rules:
- A channel whose flag is low stalls the block in the matching state for as long as the flag stays low.
- During a stall the result on the output bus does not change.
- The first operand is never overtaken by the second operand.

The datapath holds two operand registers and one shared subtractor. Multiplexers steer the larger register into the minuend and the smaller into the subtrahend. A four-state controller sequences the loads, the steps and the write.

Top module: `gcd_coproc`

## Requirements
- R1: While `rst` is high, `x_take`, `y_take` and `res_put` are all low. After reset the block first waits for the first operand.
- R2: `x_take` is high only in a cycle where `x_avail` is high and the block is waiting for a first operand. `x_data` is captured at that clock edge.
- R3: `y_take` is high only when `y_avail` is high and a first operand was taken since the last result. A second operand is never taken before its first operand.
- R4: For nonzero operands the block outputs the result of the loop "while x differs from y, subtract the smaller from the larger", which is their GCD.
- R5: If one operand is zero the block outputs the other operand without looping. If both operands are zero it outputs 0.
- R6: `res_put` is high only when `res_space` is high. While the block waits for space, `res_data` holds its value.
- R7: One subtraction takes one cycle. When every channel is ready, `res_put` occurs exactly steps+3 cycles after `x_take`, where steps is the number of subtractions.
- R8: After a result is put, the block returns to reading a first operand. With ready channels, the next `x_take` is in the very next cycle.
- R9: At most one of `x_take`, `y_take`, `res_put` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| x_data | input | 32 | First-operand FIFO data |
| x_avail | input | 1 | First-operand FIFO holds a word |
| x_take | output | 1 | Consume strobe to first-operand FIFO |
| y_data | input | 32 | Second-operand FIFO data |
| y_avail | input | 1 | Second-operand FIFO holds a word |
| y_take | output | 1 | Consume strobe to second-operand FIFO |
| res_data | output | 32 | Result word |
| res_space | input | 1 | Result FIFO can accept a word |
| res_put | output | 1 | Write strobe to result FIFO |

## Verification
A wrong state or a wrong operand register shows at the ports in several ways:
- A mistimed take strobe, visible in the same cycle.
- A second operand consumed ahead of its first.
- A wrong result word or a shifted put cycle at the end of the pair.

When the channels are held ready, the exact put cycle exposes any extra or missing subtraction step. It also exposes a missed exit on a zero operand, which would show as a hang. Pairs are matched to results in send order, so a lost or duplicated pair shifts every later comparison.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
  typedef enum logic [1:0] {
    ST_GET_X = 2'd0,
    ST_GET_Y = 2'd1,
    ST_RUN   = 2'd2,
    ST_PUT   = 2'd3
  } gcd_st_t;
endpackage

// File: rtl/gcd_sub.sv
module gcd_sub #(
  parameter int W = 32
) (
  input  logic [W-1:0] opx,
  input  logic [W-1:0] opy,
  output logic         x_lt_y,
  output logic [W-1:0] diff
);
  logic [W-1:0] minuend;
  logic [W-1:0] subtrahend;

  // steer larger value into the minuend of the single subtractor
  always_comb begin
    x_lt_y     = opx < opy;
    minuend    = x_lt_y ? opy : opx;
    subtrahend = x_lt_y ? opx : opy;
    diff       = minuend - subtrahend;
  end
endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         ld_x,
  input  logic         ld_y,
  input  logic         step,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  output logic         done,
  output logic [W-1:0] result
);
  logic [W-1:0] reg_x;
  logic [W-1:0] reg_y;
  logic [W-1:0] diff;
  logic         x_lt_y;

  gcd_sub #(.W(W)) i_sub (
    .opx    (reg_x),
    .opy    (reg_y),
    .x_lt_y (x_lt_y),
    .diff   (diff)
  );

  always_ff @(posedge clk) begin
    if (ld_x)
      reg_x <= x_in;
    else if (step && !x_lt_y)
      reg_x <= diff;
  end

  always_ff @(posedge clk) begin
    if (ld_y)
      reg_y <= y_in;
    else if (step && x_lt_y)
      reg_y <= diff;
  end

  always_comb begin
    done   = (reg_x == reg_y) || (reg_x == '0) || (reg_y == '0);
    result = (reg_x == '0) ? reg_y : reg_x;
  end
endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
  import gcd_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    x_avail,
  input  logic    y_avail,
  input  logic    res_space,
  input  logic    done,
  output logic    ld_x,
  output logic    ld_y,
  output logic    step,
  output logic    put,
  output gcd_st_t st
);
  gcd_st_t st_nxt;

  always_ff @(posedge clk) begin
    if (rst) st <= ST_GET_X;
    else     st <= st_nxt;
  end

  always_comb begin
    st_nxt = st;
    ld_x   = 1'b0;
    ld_y   = 1'b0;
    step   = 1'b0;
    put    = 1'b0;
    if (!rst) begin
      unique case (st)
        ST_GET_X: if (x_avail) begin
          ld_x   = 1'b1;
          st_nxt = ST_GET_Y;
        end
        ST_GET_Y: if (y_avail) begin
          ld_y   = 1'b1;
          st_nxt = ST_RUN;
        end
        ST_RUN: begin
          if (done) st_nxt = ST_PUT;
          else      step   = 1'b1;
        end
        ST_PUT: if (res_space) begin
          put    = 1'b1;
          st_nxt = ST_GET_X;
        end
        default: st_nxt = ST_GET_X;
      endcase
    end
  end
endmodule

// File: rtl/gcd_coproc.sv
module gcd_coproc
  import gcd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] x_data,
  input  logic         x_avail,
  output logic         x_take,
  input  logic [W-1:0] y_data,
  input  logic         y_avail,
  output logic         y_take,
  output logic [W-1:0] res_data,
  input  logic         res_space,
  output logic         res_put
);
  logic    ld_x, ld_y, step, done;
  gcd_st_t st;

  gcd_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .x_avail   (x_avail),
    .y_avail   (y_avail),
    .res_space (res_space),
    .done      (done),
    .ld_x      (ld_x),
    .ld_y      (ld_y),
    .step      (step),
    .put       (res_put),
    .st        (st)
  );

  gcd_datapath #(.W(W)) i_dp (
    .clk    (clk),
    .ld_x   (ld_x),
    .ld_y   (ld_y),
    .step   (step),
    .x_in   (x_data),
    .y_in   (y_data),
    .done   (done),
    .result (res_data)
  );

  assign x_take = ld_x;
  assign y_take = ld_y;
endmodule

// File: rtl/gcd_coproc_chk.sv
module gcd_coproc_chk
  import gcd_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         x_avail,
  input logic         x_take,
  input logic         y_avail,
  input logic         y_take,
  input logic         res_space,
  input logic         res_put,
  input logic [W-1:0] res_data,
  input gcd_st_t      st
);
  logic have_x, have_y;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_x <= 1'b0;
      have_y <= 1'b0;
    end else begin
      if (x_take)       have_x <= 1'b1;
      else if (y_take)  have_x <= 1'b0;
      if (y_take)       have_y <= 1'b1;
      else if (res_put) have_y <= 1'b0;
    end
  end

  AST_QUIET_IN_RESET: assert property (@(posedge clk) rst |-> !(x_take || y_take || res_put)); // R1
  AST_X_GATED: assert property (@(posedge clk) disable iff (rst) x_take |-> x_avail); // R2
  AST_X_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst) x_take |-> (!have_x && !have_y)); // R2
  AST_Y_GATED: assert property (@(posedge clk) disable iff (rst) y_take |-> y_avail); // R3
  AST_Y_AFTER_X: assert property (@(posedge clk) disable iff (rst) y_take |-> have_x); // R3
  AST_PUT_GATED: assert property (@(posedge clk) disable iff (rst) res_put |-> res_space); // R6
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst) (st == ST_PUT && !res_space) |=> $stable(res_data)); // R6
  AST_PUT_AFTER_PAIR: assert property (@(posedge clk) disable iff (rst) res_put |-> have_y); // R8
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst) $onehot0({x_take, y_take, res_put})); // R9
endmodule

bind gcd_coproc gcd_coproc_chk #(.W(W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .x_avail   (x_avail),
  .x_take    (x_take),
  .y_avail   (y_avail),
  .y_take    (y_take),
  .res_space (res_space),
  .res_put   (res_put),
  .res_data  (res_data),
  .st        (st)
);

// File: tb/test_gcd_coproc.sv
module test_gcd_coproc;
  localparam int W  = 32;
  localparam int ND = 9;
  localparam int NP = 129;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] x_data = '0, y_data = '0;
  logic         x_avail = 1'b0, y_avail = 1'b0, res_space = 1'b0;
  logic         x_take, y_take, res_put;
  logic [W-1:0] res_data;

  always #2 clk = ~clk;

  gcd_coproc #(.W(W)) i_gcd_coproc (
    .clk(clk), .rst(rst),
    .x_data(x_data), .x_avail(x_avail), .x_take(x_take),
    .y_data(y_data), .y_avail(y_avail), .y_take(y_take),
    .res_data(res_data), .res_space(res_space), .res_put(res_put)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [W-1:0] opx [NP];
  logic [W-1:0] opy [NP];
  logic [W-1:0] exp_r [NP];
  int           exp_s [NP];
  int           t_take [NP];
  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  function automatic logic [W-1:0] ref_gcd(input logic [W-1:0] a, input logic [W-1:0] b, output int steps);
    steps = 0;
    if (a == 0) return b;
    if (b == 0) return a;
    while (a != b) begin
      if (a < b) b = b - a;
      else       a = a - b;
      steps++;
    end
    return a;
  endfunction

  int  ix = 0, iy = 0, ir = 0, last_put = -10;
  bit  inc_x = 0, inc_y = 0, full, timeout = 0;

  initial begin
    void'($urandom(32'd20240611));
    opx[0] = 32'd12;         opy[0] = 32'd18;
    opx[1] = 32'd0;          opy[1] = 32'd0;
    opx[2] = 32'd0;          opy[2] = 32'd7;
    opx[3] = 32'd9;          opy[3] = 32'd0;
    opx[4] = 32'd5;          opy[4] = 32'd5;
    opx[5] = 32'h8000_0000;  opy[5] = 32'h4000_0000;
    opx[6] = 32'hFFFF_FFFF;  opy[6] = 32'hFFFF_FFFF;
    opx[7] = 32'd7;          opy[7] = 32'd3;
    opx[8] = 32'd3;          opy[8] = 32'd1000;
    for (int k = ND; k < NP; k++) begin
      logic [W-1:0] f;
      f = $urandom_range(1, 32'hFF_FFFF);
      opx[k] = f * $urandom_range(0, 199);
      opy[k] = f * $urandom_range(0, 199);
    end
    for (int k = 0; k < NP; k++) exp_r[k] = ref_gcd(opx[k], opy[k], exp_s[k]);

    // reset with every channel offering traffic
    x_avail = 1'b1; y_avail = 1'b1; res_space = 1'b1;
    x_data = opx[0]; y_data = opy[0];
    repeat (4) begin
      @(negedge clk); #1;
      chk(!(x_take || y_take || res_put), "R1 strobes in reset",
          {29'd0, x_take, y_take, res_put}, '0);
    end
    @(negedge clk); rst = 1'b0;
    #1 chk(x_take == 1'b1 && y_take == 1'b0, "R1 waits for first operand",
           {30'd0, x_take, y_take}, 32'd2);
    inc_x = x_take; t_take[0] = cyc;

    while (ir < NP && !timeout) begin
      @(negedge clk);
      if (inc_x) ix++;
      if (inc_y) iy++;
      inc_x = 0; inc_y = 0;
      full = (ir < ND);
      x_avail   = (ix < NP) && (full || $urandom_range(0, 2) != 0);
      y_avail   = (iy < NP) && (full || $urandom_range(0, 2) != 0);
      res_space = full || $urandom_range(0, 3) != 0;
      x_data = opx[(ix < NP) ? ix : 0];
      y_data = opy[(iy < NP) ? iy : 0];
      #1;
      if (x_take) begin
        chk(x_avail, "R2 take without avail", {31'd0, x_take}, {31'd0, x_avail});
        chk(ix == iy, "R2 first operand while pair open", ix, iy);
        if (full && ix > 0) chk(cyc == last_put + 1, "R8 back-to-back read", cyc, last_put + 1);
        if (ix < NP) t_take[ix] = cyc;
        inc_x = 1;
      end
      if (y_take) begin
        chk(y_avail, "R3 take without avail", {31'd0, y_take}, {31'd0, y_avail});
        chk(ix == iy + 1, "R3 second operand order", iy, ix - 1);
      end
      if (y_take) inc_y = 1;
      if (!res_space) chk(!res_put, "R6 put without space", {31'd0, res_put}, '0);
      if (x_take || y_take || res_put)
        chk($countones({x_take, y_take, res_put}) == 1, "R9 single strobe",
            {29'd0, x_take, y_take, res_put}, '0);
      if (res_put) begin
        if (opx[ir] == 0 || opy[ir] == 0)
          chk(res_data == exp_r[ir], "R5 zero operand result", res_data, exp_r[ir]);
        else
          chk(res_data == exp_r[ir], "R4 gcd result", res_data, exp_r[ir]);
        if (ir < ND)
          chk(cyc - t_take[ir] == exp_s[ir] + 3, "R7 latency", cyc - t_take[ir], exp_s[ir] + 3);
        last_put = cyc;
        ir++;
      end
      if (cyc > 150000) begin
        timeout = 1;
        chk(1'b0, "watchdog expired", ir, NP);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule